// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block is the core of a small interrupt controller. It watches seven request sources: three timers, two DMA channels and two external interrupt pins. Each request is latched into a pending flag, and arbitration picks one eligible source by a fixed priority and raises a single interrupt line to the CPU. When the CPU pulses its acknowledge, the block moves the winning source from pending to in-service and holds that source's type code on an output as the vector.

A source that is in service holds back itself and every source of equal or lower priority until software writes that source's type code to the end-of-interrupt address. A nesting mode input lifts the self-block for the two external pins only. A per-source mask input hides a pending source from the CPU but does not stop it being latched. Software reads the pending register and the in-service register through a small register bus.

Top module: `irq_track`

## Requirements
- R1: After reset, both readable registers return 0000h, `cpu_irq` is low and `vec_type` is 00h.
- R2: Reading address 0 returns the pending register. Timer 0 is bit 0, DMA 0 is bit 2, DMA 1 is bit 3, timer 1 is bit 4 and timer 2 is bit 5. Bit 1 and bits 15..6 read as zero, and the external pins never appear there. Address 2 and address 3 read as zero.
- R3: A request that is high at a clock edge sets its pending flag, and the flag stays set after the request drops until that source is acknowledged.
- R4: Among eligible sources, the winner is the first in this order: timer 0, timer 1, timer 2, DMA 0, DMA 1, int0, int1. The three timers share one priority level. Each of the other sources has a level of its own, and the levels follow the same order.
- R5: When `cpu_ack` is high while `cpu_irq` is high, the next edge clears the winner's pending flag, sets its in-service flag and loads `vec_type` with its type code. The type codes are timer 0 = 8, timer 1 = 18, timer 2 = 19, DMA 0 = 10, DMA 1 = 11, int0 = 12 and int1 = 13. Reading address 1 returns the in-service register. It uses the same bit positions as the pending register, with int0 at bit 6 and int1 at bit 7.
- R6: A set in-service flag blocks every source whose level is the same as its own or lower. When `cpu_irq` is low, no unmasked pending source is unblocked.
- R7: While `nest_mode` is high, int0 and int1 are not blocked by their own in-service flag. They are still blocked by higher levels.
- R8: A bus write to address 2 whose low byte equals a source's type code clears that source's in-service flag at the next edge.
- R9: An end-of-interrupt write whose low byte matches no type code leaves both registers unchanged.
- R10: If a request is still high after its acknowledge, its pending flag is set again one cycle later.
- R11: A set `src_mask` bit (bit order as in R4) keeps that source from raising `cpu_irq`, but its pending flag is still set.
- R12: `cpu_ack` while `cpu_irq` is low changes neither `vec_type` nor either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_req | input | 3 | Timer requests, bit n is timer n |
| dma_req | input | 2 | DMA channel requests |
| ext_req | input | 2 | External pin requests, bit 0 is int0 |
| src_mask | input | 7 | Per-source mask, in R4 order |
| nest_mode | input | 1 | Lets int0/int1 re-enter themselves |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | Single-cycle acknowledge strobe |
| vec_type | output | 8 | Type code of the last acknowledged source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data, low byte is the type code |
| bus_rdata | output | 16 | Read data |

## Verification
Directed sequences cover several cases, each aimed at one rule:
- A one-cycle timer pulse shows that the pending flag is latched and is not a copy of the request level.
- Timer, DMA and int0 requests pending together show the arbitration order, one acknowledge at a time.
- A held int0 request tells self-blocking apart from nesting mode, because the bench flips `nest_mode` while that request stays high.
- An all-ones mask combined with a stray acknowledge separates masking from acknowledgement.

Random traffic then mixes requests, masks, acknowledges and end-of-interrupt writes with both valid and junk codes, against a behavioural model checked every cycle.

// File: rtl/irq_track_pkg.sv
// Package: shared constants and source attribute functions for the
// interrupt tracker. Assumes sources are indexed timer0..2, dma0..1, int0..1.
package irq_track_pkg;

    localparam int NSRC   = 7;
    localparam int NLVL   = 5;
    localparam int TYPE_W = 8;

    localparam logic [1:0] ADDR_PEND = 2'd0;
    localparam logic [1:0] ADDR_ISRV = 2'd1;
    localparam logic [1:0] ADDR_EOI  = 2'd2;

    typedef enum logic [2:0] {
        SRC_TMR0 = 3'd0,
        SRC_TMR1 = 3'd1,
        SRC_TMR2 = 3'd2,
        SRC_DMA0 = 3'd3,
        SRC_DMA1 = 3'd4,
        SRC_INT0 = 3'd5,
        SRC_INT1 = 3'd6
    } src_e;

    // Priority level of a source; lower level wins, timers share level 0.
    function automatic int src_level(input int s);
        case (s)
            0, 1, 2: return 0;
            3:       return 1;
            4:       return 2;
            5:       return 3;
            default: return 4;
        endcase
    endfunction

    // Interrupt type code reported as the vector for a source.
    function automatic logic [TYPE_W-1:0] src_type(input int s);
        case (s)
            0:       return 8'd8;
            1:       return 8'd18;
            2:       return 8'd19;
            3:       return 8'd10;
            4:       return 8'd11;
            5:       return 8'd12;
            default: return 8'd13;
        endcase
    endfunction

    // Whether a source is an external pin (eligible for nesting bypass).
    function automatic logic src_is_ext(input int s);
        return (s == 5) || (s == 6);
    endfunction

    // Bit position in the pending register view, -1 when not shown.
    function automatic int pend_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 4;
            2:       return 5;
            3:       return 2;
            4:       return 3;
            default: return -1;
        endcase
    endfunction

    // Bit position in the in-service register view.
    function automatic int isrv_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 4;
            2:       return 5;
            3:       return 2;
            4:       return 3;
            5:       return 6;
            default: return 7;
        endcase
    endfunction

    // True when a code equals the type code of any source.
    function automatic logic type_known(input logic [TYPE_W-1:0] t);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_type(s) == t) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/irq_track_pend.sv
// Module: pending flags. One flag per source, set by a request level seen at
// an edge, cleared by a one-hot take strobe. Take wins over a same-cycle set.
module irq_track_pend
    import irq_track_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] take,
    output logic [N-1:0] pend
);

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_flag
            // Latch the request; clear it when the source is taken.
            always_ff @(posedge clk) begin
                if (!rst_n)       pend[s] <= 1'b0;
                else if (take[s]) pend[s] <= 1'b0;
                else if (req[s])  pend[s] <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_track_inserv.sv
// Module: in-service flags. Set by a one-hot take strobe, cleared by an
// end-of-interrupt write carrying the source's type code. Set wins.
module irq_track_inserv
    import irq_track_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      take,
    input  logic              eoi_wr,
    input  logic [TYPE_W-1:0] eoi_type,
    output logic [N-1:0]      isrv
);

    logic [N-1:0] clr;

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_flag
            assign clr[s] = eoi_wr && (eoi_type == src_type(s));

            // Mark taken sources busy until their end-of-interrupt.
            always_ff @(posedge clk) begin
                if (!rst_n)       isrv[s] <= 1'b0;
                else if (take[s]) isrv[s] <= 1'b1;
                else if (clr[s])  isrv[s] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_track_arb.sv
// Module: eligibility and fixed-priority arbitration. Purely combinational.
// Assumes lower source index never has a higher level than a larger index.
module irq_track_arb
    import irq_track_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int L     = NLVL,
    localparam int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    mask,
    input  logic [N-1:0]    isrv,
    input  logic            nest_mode,
    output logic            irq,
    output logic [N-1:0]    win_oh,
    output logic [IDXW-1:0] win_idx
);

    logic [L-1:0] lvl_busy;
    logic [N-1:0] elig;

    // Collect which priority levels hold an in-service source.
    always_comb begin
        lvl_busy = '0;
        for (int s = 0; s < N; s++) begin
            if (isrv[s]) lvl_busy[src_level(s)] = 1'b1;
        end
    end

    // Decide per source whether it may interrupt now.
    always_comb begin
        for (int s = 0; s < N; s++) begin
            logic blk;
            blk = 1'b0;
            for (int l = 0; l < L; l++) begin
                if (l < src_level(s) && lvl_busy[l]) blk = 1'b1;
            end
            if (lvl_busy[src_level(s)] && !(nest_mode && src_is_ext(s)))
                blk = 1'b1;
            elig[s] = pend[s] && !mask[s] && !blk;
        end
    end

    // Pick the lowest-index eligible source.
    always_comb begin
        logic found;
        found   = 1'b0;
        win_oh  = '0;
        win_idx = '0;
        for (int s = 0; s < N; s++) begin
            if (elig[s] && !found) begin
                found      = 1'b1;
                win_oh[s]  = 1'b1;
                win_idx    = IDXW'(s);
            end
        end
        irq = found;
    end

endmodule

// File: rtl/irq_track.sv
// Module: top of the interrupt tracker. Gathers requests, runs arbitration,
// applies the acknowledge, holds the vector and serves register reads and
// end-of-interrupt writes. Assumes cpu_ack is a one-cycle strobe.
module irq_track
    import irq_track_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        tmr_req,
    input  logic [1:0]        dma_req,
    input  logic [1:0]        ext_req,
    input  logic [NSRC-1:0]   src_mask,
    input  logic              nest_mode,
    output logic              cpu_irq,
    input  logic              cpu_ack,
    output logic [TYPE_W-1:0] vec_type,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int IDXW = $clog2(NSRC);

    logic [NSRC-1:0] req_all;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] isrv_q;
    logic [NSRC-1:0] win_oh;
    logic [IDXW-1:0] win_idx;
    logic [NSRC-1:0] take;
    logic            take_any;
    logic            eoi_wr;
    logic [DATA_W-1:0] pend_view;
    logic [DATA_W-1:0] isrv_view;

    assign req_all  = {ext_req, dma_req, tmr_req};
    assign take_any = cpu_ack && cpu_irq;
    assign take     = take_any ? win_oh : '0;
    assign eoi_wr   = bus_wr && (bus_addr == ADDR_W'(ADDR_EOI));

    irq_track_pend #(.N(NSRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_all),
        .take (take),
        .pend (pend_q)
    );

    irq_track_inserv #(.N(NSRC)) u_isrv (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .eoi_wr  (eoi_wr),
        .eoi_type(bus_wdata[TYPE_W-1:0]),
        .isrv    (isrv_q)
    );

    irq_track_arb #(.N(NSRC), .L(NLVL)) u_arb (
        .pend     (pend_q),
        .mask     (src_mask),
        .isrv     (isrv_q),
        .nest_mode(nest_mode),
        .irq      (cpu_irq),
        .win_oh   (win_oh),
        .win_idx  (win_idx)
    );

    // Capture the winner's type code on an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_type <= '0;
        else if (take_any) vec_type <= src_type(int'(win_idx));
    end

    // Map internal flags onto the register bit layout.
    always_comb begin
        pend_view = '0;
        isrv_view = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (pend_pos(s) >= 0) pend_view[pend_pos(s)] = pend_q[s];
            isrv_view[isrv_pos(s)] = isrv_q[s];
        end
    end

    // Select read data by address; other addresses read zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(ADDR_PEND): bus_rdata = pend_view;
            ADDR_W'(ADDR_ISRV): bus_rdata = isrv_view;
            default:            bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_track_chk.sv
// Module: assertion checker bound to irq_track.
module irq_track_chk
    import irq_track_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_irq,
    input logic              cpu_ack,
    input logic [TYPE_W-1:0] vec_type,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [NSRC-1:0]   src_mask,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   inserv
);

    // R5
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq) |=> (vec_type != 8'h00));

    // R12
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ack && cpu_irq) |=> $stable(vec_type));

    // R11
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((pend & ~src_mask) != '0));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_PEND) |-> (bus_rdata[15:6] == 10'd0 && !bus_rdata[1]));

    // R6
    tmr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inserv[2:0]) <= 1);

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> ((pend & $past(pend)) == $past(pend)));

    // R9
    eoi_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_EOI && !type_known(bus_wdata[7:0]) &&
         !(cpu_ack && cpu_irq)) |=> $stable(inserv));

endmodule

bind irq_track irq_track_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_irq  (cpu_irq),
    .cpu_ack  (cpu_ack),
    .vec_type (vec_type),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_mask (src_mask),
    .pend     (pend_q),
    .inserv   (isrv_q)
);

// File: tb/irq_track_bench.sv
`timescale 1ns/100ps
module irq_track_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tmr_req = '0;
    logic [1:0]  dma_req = '0;
    logic [1:0]  ext_req = '0;
    logic [6:0]  src_mask = '0;
    logic        nest_mode = 1'b0;
    logic        cpu_irq;
    logic        cpu_ack = 1'b0;
    logic [7:0]  vec_type;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference
    int lvl[7]  = '{0, 0, 0, 1, 2, 3, 4};
    int typ[7]  = '{8, 18, 19, 10, 11, 12, 13};
    int ppos[7] = '{0, 4, 5, 2, 3, -1, -1};
    int ipos[7] = '{0, 4, 5, 2, 3, 6, 7};
    bit m_pend[7];
    bit m_isrv[7];
    int m_vec;

    always #2.5 clk = ~clk;

    irq_track u_irq_track (
        .clk(clk), .rst_n(rst_n), .tmr_req(tmr_req), .dma_req(dma_req),
        .ext_req(ext_req), .src_mask(src_mask), .nest_mode(nest_mode),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .vec_type(vec_type),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit m_req(int s);
        logic [6:0] r;
        r = {ext_req, dma_req, tmr_req};
        return r[s];
    endfunction

    function automatic int m_winner();
        for (int s = 0; s < 7; s++) begin
            bit blocked;
            blocked = 0;
            for (int t = 0; t < 7; t++) begin
                if (m_isrv[t] && lvl[t] < lvl[s]) blocked = 1;
                if (m_isrv[t] && lvl[t] == lvl[s] && !(nest_mode && s >= 5 && t == s))
                    blocked = 1;
            end
            if (m_pend[s] && !src_mask[s] && !blocked) return s;
        end
        return -1;
    endfunction

    function automatic logic [15:0] m_rd(logic [1:0] a);
        logic [15:0] v;
        v = '0;
        for (int s = 0; s < 7; s++) begin
            if (a == 2'd0 && ppos[s] >= 0) v[ppos[s]] = m_pend[s];
            if (a == 2'd1) v[ipos[s]] = m_isrv[s];
        end
        return v;
    endfunction

    task automatic m_update();
        int w;
        bit acc;
        w = m_winner();
        acc = cpu_ack && (w >= 0);
        for (int s = 0; s < 7; s++) begin
            if (acc && s == w) m_pend[s] = 0;
            else if (m_req(s)) m_pend[s] = 1;
            if (acc && s == w) m_isrv[s] = 1;
            else if (bus_wr && bus_addr == 2'd2 && bus_wdata[7:0] == typ[s][7:0])
                m_isrv[s] = 0;
        end
        if (acc) m_vec = typ[w];
    endtask

    // One clock: compare against the model, advance both, back to negedge.
    task automatic tick();
        #0.2;
        chk("R6 cpu_irq", {15'd0, cpu_irq}, {15'd0, m_winner() >= 0});
        chk("R5 vec_type", {8'd0, vec_type}, m_vec[15:0]);
        chk(bus_addr == 2'd1 ? "R8 rdata" : "R2 rdata", bus_rdata, m_rd(bus_addr));
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        #0.1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] t);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = {8'd0, t};
        tick();
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 7; s++) begin m_pend[s] = 0; m_isrv[s] = 0; end
        m_vec = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, 16'h0000, "R1 pend");
        rd(2'd1, 16'h0000, "R1 isrv");
        chk("R1 irq", {15'd0, cpu_irq}, 16'd0);
        chk("R1 vec", {8'd0, vec_type}, 16'd0);

        // R3 one-cycle pulse on timer 1 stays latched
        tmr_req = 3'b010; tick(); tmr_req = '0;
        dma_req = 2'b01; ext_req = 2'b01; tick(); dma_req = '0;
        rd(2'd0, 16'h0014, "R2 R3 pend layout");
        chk("R3 irq", {15'd0, cpu_irq}, 16'd1);

        // R4 timer 1 wins over DMA 0 and int0
        bus_addr = 2'd0; ack();
        chk("R4 vec tmr1", {8'd0, vec_type}, 16'd18);
        rd(2'd1, 16'h0010, "R5 isrv tmr1");
        rd(2'd0, 16'h0004, "R5 pend after ack");
        #0.1 chk("R6 lower blocked", {15'd0, cpu_irq}, 16'd0);

        // R9 junk EOI ignored
        eoi(8'h55);
        rd(2'd1, 16'h0010, "R9 isrv kept");
        rd(2'd0, 16'h0004, "R9 pend kept");

        // R8 matching EOI clears
        eoi(8'd18);
        rd(2'd1, 16'h0000, "R8 isrv cleared");
        chk("R8 irq back", {15'd0, cpu_irq}, 16'd1);

        ack();
        chk("R4 vec dma0", {8'd0, vec_type}, 16'd10);
        #0.1 chk("R6 int0 blocked", {15'd0, cpu_irq}, 16'd0);
        eoi(8'd10);
        ack();
        chk("R5 vec int0", {8'd0, vec_type}, 16'd12);
        rd(2'd1, 16'h0040, "R5 isrv int0");
        tick();
        #0.1 chk("R6 self block", {15'd0, cpu_irq}, 16'd0);
        nest_mode = 1'b1;
        #0.1 chk("R7 R10 nested re-request", {15'd0, cpu_irq}, 16'd1);
        ack();
        ext_req = '0; nest_mode = 1'b0;
        chk("R7 vec int0 again", {8'd0, vec_type}, 16'd12);
        eoi(8'd12);
        rd(2'd1, 16'h0000, "R8 isrv empty");

        // R11 mask, R12 stray ack
        src_mask = 7'h7F; tmr_req = 3'b001; tick(); tmr_req = '0;
        rd(2'd0, 16'h0001, "R11 pend kept");
        chk("R11 irq masked", {15'd0, cpu_irq}, 16'd0);
        ack();
        chk("R12 vec stable", {8'd0, vec_type}, 16'd12);
        rd(2'd0, 16'h0001, "R12 pend stable");
        rd(2'd1, 16'h0000, "R12 isrv stable");
        src_mask = '0;
        ack();
        chk("R5 vec tmr0", {8'd0, vec_type}, 16'd8);
        eoi(8'd8);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            tmr_req   = 3'($urandom_range(0, 7) & $urandom_range(0, 7));
            dma_req   = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            ext_req   = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
            src_mask  = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'd0;
            if ($urandom_range(0, 31) == 0) nest_mode = ~nest_mode;
            cpu_ack   = ($urandom_range(0, 2) == 0);
            bus_wr    = ($urandom_range(0, 4) == 0);
            bus_addr  = 2'($urandom_range(0, 3));
            if (bus_wr) bus_addr = ($urandom_range(0, 3) == 0) ? 2'd1 : 2'd2;
            bus_wdata = ($urandom_range(0, 3) == 0) ? 16'($urandom) :
                        16'(typ[$urandom_range(0, 6)]);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule